// File: doc/BRIEF.md
# Dual-Field Binary-GCD Modular Divider

This block computes the modular quotient q = X / Y mod M directly. It does not form an inverse and then multiply. It runs a binary extended-GCD iteration on four working registers: two remainders and two coefficients. The field is chosen per operation. The prime field treats operands as integers with an odd modulus. The binary field treats them as polynomials over GF(2) with an irreducible modulus whose constant term is one. One datapath serves both fields. In the binary field, XOR replaces subtraction and a degree comparison replaces the magnitude comparison.

Each round makes all its decisions from the least significant bit of the remainder register, so a new round starts on every clock. A round that subtracts also halves in the same cycle, because the difference of two odd values is always even. After a swap, the untouched remainder stays odd and never needs halving. Because of this, every round shrinks the product (or the degree sum) of the remainders by at least one bit. An operation therefore ends within 2·len rounds, where len is the run-time operand length, up to the parameter W.

A caller drives the operands together with a one-cycle `start` while the block is idle. The block then holds `busy` until it raises `done` for one cycle, with the quotient on `q_out`, or with `err` set if no quotient exists.

Top module: `gcd_moddiv`

## Requirements
- R1: After reset `busy`, `done`, `err` are 0 and `q_out` is 0.
- R2: A `start` seen while idle latches `field_sel`, `len_in`, `x_in`, `y_in`, `m_in` and raises `busy` in the next cycle. `done` is a one-cycle pulse with `busy` low in the same cycle. `q_out` and `err` then hold their values until the next accepted `start`.
- R3: With `field_sel`=0 (prime field), odd M, X < M and gcd(Y,M)=1, `q_out` < M and q_out·Y mod M = X.
- R4: With `field_sel`=1 (binary field), bit i of an operand is the coefficient of x^i. For an irreducible M of degree len_in-1 and X, Y of lower degree with Y≠0, deg(q_out) < deg(M) and q_out·Y reduced mod M equals X (for example M=0x11B, X=1, Y=0x53 gives 0xCA).
- R5: When Y = 1, `q_out` = X and `done` rises exactly two clock cycles after the cycle in which `start` was driven.
- R6: When X = 0 and Y is invertible, `q_out` = 0 with `err` = 0.
- R7: When Y = 0, or when Y shares a factor with M, the operation ends with `err`=1 and `q_out`=0.
- R8: An operation that has not finished after 2·len_in rounds ends with `err`=1. No operation takes more than 2·len_in+2 cycles from `start` to `done`.
- R9: A `start` driven while `busy` is ignored. The running operation finishes with the result for its own operands.
- R10: `len_in` only bounds the iteration. It may be any value from the bit length of M up to W, and the same operands give the same quotient at every such length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| field_sel | input | 1 | 0 = prime field, 1 = binary field |
| len_in | input | LW | Operand length in bits (bit length of M) |
| x_in | input | W | Dividend X |
| y_in | input | W | Divisor Y |
| m_in | input | W | Modulus M (odd / constant term 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation had no quotient or ran out of rounds |
| q_out | output | W | Quotient X/Y mod M, held until next start |

## Verification
The round-limit error is the hardest case to reach from the ports. For valid operands, the shrinking-product argument guarantees the loop ends early, so the limit never fires. The stimulus forces it by declaring a length far shorter than the real operands: a 32-bit modulus with `len_in`=2. The divisor then needs about thirty halvings, but only four rounds are allowed. The block must flag `err` after exactly 2·len_in+2 cycles. The swap branch is reached with full-width operands, where the divisor must repeatedly overtake the remainder. It is checked through the product identity rather than a stored answer.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
    typedef enum logic {
        F_PRIME = 1'b0,
        F_BIN   = 1'b1
    } field_e;
endpackage

// File: rtl/mdiv_fill.sv
// Smears the leading one of a value down to bit 0; comparing the smeared
// value against another operand tells whether its degree is not smaller.
module mdiv_fill #(
    parameter int W = 64
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] fill_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fill_o[i] = |val_i[W-1:i];
    end
endmodule

// File: rtl/mdiv_submod.sv
// Integer (p - q) mod m for p, q < m.
module mdiv_submod #(
    parameter int W = 64
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] m_i,
    output logic [W-1:0] r_o
);
    logic [W:0] diff;
    logic [W:0] wrap;

    always_comb begin
        diff = {1'b0, p_i} - {1'b0, q_i};
        wrap = diff + {1'b0, m_i};
        r_o  = diff[W] ? wrap[W-1:0] : diff[W-1:0];
    end
endmodule

// File: rtl/mdiv_halve.sv
// Division by two modulo m in either field.
module mdiv_halve #(
    parameter int W = 64
) (
    input  mdiv_pkg::field_e fld_i,
    input  logic [W-1:0]     val_i,
    input  logic [W-1:0]     m_i,
    output logic [W-1:0]     half_o
);
    logic [W:0]   sum;
    logic [W-1:0] folded;

    always_comb begin
        sum    = {1'b0, val_i} + (val_i[0] ? {1'b0, m_i} : '0);
        folded = val_i ^ (val_i[0] ? m_i : '0);
        if (fld_i == mdiv_pkg::F_BIN) half_o = folded >> 1;
        else                          half_o = sum[W:1];
    end
endmodule

// File: rtl/gcd_moddiv.sv
module gcd_moddiv #(
    parameter int W  = 64,
    parameter int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          field_sel,
    input  logic [LW-1:0] len_in,
    input  logic [W-1:0]  x_in,
    input  logic [W-1:0]  y_in,
    input  logic [W-1:0]  m_in,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [W-1:0]  q_out
);
    import mdiv_pkg::*;

    localparam int CW = LW + 1;

    typedef struct packed {
        logic          run;
        field_e        fld;
        logic [LW-1:0] len;
        logic [CW-1:0] cnt;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [W-1:0]  u;
        logic [W-1:0]  v;
        logic [W-1:0]  m;
        logic [W-1:0]  q;
        logic          done;
        logic          err;
    } st_t;

    st_t s_q, s_d;

    logic          a_odd_d;
    logic          ge_d;
    logic [W-1:0]  fill_a_d;
    logic [W-1:0]  sub_p_d, sub_q_d, smod_d;
    logic [W-1:0]  uv_d, diff_d, h_in_d, h_out_d;
    logic [CW-1:0] limit_d;

    mdiv_fill #(.W(W)) u_fill (
        .val_i (s_q.a),
        .fill_o(fill_a_d)
    );

    mdiv_submod #(.W(W)) u_sub (
        .p_i(sub_p_d),
        .q_i(sub_q_d),
        .m_i(s_q.m),
        .r_o(smod_d)
    );

    mdiv_halve #(.W(W)) u_half (
        .fld_i (s_q.fld),
        .val_i (h_in_d),
        .m_i   (s_q.m),
        .half_o(h_out_d)
    );

    // Decisions of the round, all from the LSB of a and one comparison.
    always_comb begin
        a_odd_d = s_q.a[0];
        if (s_q.fld == F_BIN) ge_d = (fill_a_d >= s_q.b);
        else                  ge_d = (s_q.a >= s_q.b);
        sub_p_d = ge_d ? s_q.u : s_q.v;
        sub_q_d = ge_d ? s_q.v : s_q.u;
        if (s_q.fld == F_BIN) begin
            uv_d   = s_q.u ^ s_q.v;
            diff_d = s_q.a ^ s_q.b;
        end else begin
            uv_d   = smod_d;
            diff_d = ge_d ? (s_q.a - s_q.b) : (s_q.b - s_q.a);
        end
        h_in_d  = a_odd_d ? uv_d : s_q.u;
        limit_d = {s_q.len, 1'b0};
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.run) begin
            if (start) begin
                s_d.run = 1'b1;
                s_d.fld = field_e'(field_sel);
                s_d.len = len_in;
                s_d.cnt = '0;
                s_d.a   = y_in;
                s_d.b   = m_in;
                s_d.u   = x_in;
                s_d.v   = '0;
                s_d.m   = m_in;
                s_d.q   = '0;
                s_d.err = 1'b0;
            end
        end else if (s_q.a == W'(1)) begin
            s_d.run  = 1'b0;
            s_d.done = 1'b1;
            s_d.q    = s_q.u;
        end else if (s_q.a == '0 || s_q.cnt == limit_d) begin
            s_d.run  = 1'b0;
            s_d.done = 1'b1;
            s_d.err  = 1'b1;
            s_d.q    = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            s_d.u   = h_out_d;
            if (a_odd_d) begin
                s_d.a = diff_d >> 1;
                s_d.b = ge_d ? s_q.b : s_q.a;
                s_d.v = ge_d ? s_q.v : s_q.u;
            end else begin
                s_d.a = s_q.a >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.run;
    assign done  = s_q.done;
    assign err   = s_q.err;
    assign q_out = s_q.q;

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.cnt <= limit_d));
    a_r3_coef_range: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.fld == F_PRIME) |-> (s_q.u < s_q.m && s_q.v < s_q.m));
    a_r4_b_stays_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.m[0]) |-> s_q.b[0]);
    a_r7_err_zero_q: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (q_out == '0));
    a_r9_hold_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(s_q.m) && $stable(s_q.fld)));
endmodule

// File: tb/sim_gcd_moddiv.sv
module sim_gcd_moddiv;
    localparam int W  = 32;
    localparam int LW = 6;

    typedef struct packed {
        logic          fld;
        logic [LW-1:0] len;
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W-1:0]  m;
        logic          xerr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT[NV] = '{
        '{1'b0, 6'd5,  32'd7,         32'd3,         32'd23,         1'b0},
        '{1'b0, 6'd20, 32'd12345,     32'd678,       32'd1000003,    1'b0},
        '{1'b0, 6'd32, 32'd123456789, 32'd987654321, 32'hFFFFFFFB,   1'b0},
        '{1'b0, 6'd32, 32'hFFFFFFF0,  32'hFFFFFFF9,  32'hFFFFFFFB,   1'b0},
        '{1'b0, 6'd32, 32'd0,         32'd55555,     32'hFFFFFFFB,   1'b0},
        '{1'b1, 6'd5,  32'h9,         32'h6,         32'h13,         1'b0},
        '{1'b1, 6'd9,  32'h1,         32'h53,        32'h11B,        1'b0},
        '{1'b1, 6'd32, 32'h12345678,  32'h0ABCDEF1,  32'h80000009,   1'b0},
        '{1'b0, 6'd5,  32'd5,         32'd14,        32'd21,         1'b1},
        '{1'b1, 6'd5,  32'h3,         32'h7,         32'h15,         1'b1},
        '{1'b0, 6'd5,  32'd4,         32'd0,         32'd23,         1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          field_sel = 1'b0;
    logic [LW-1:0] len_in = '0;
    logic [W-1:0]  x_in = '0, y_in = '0, m_in = '0;
    logic          busy, done, err;
    logic [W-1:0]  q_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    gcd_moddiv #(.W(W), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
        .len_in(len_in), .x_in(x_in), .y_in(y_in), .m_in(m_in),
        .busy(busy), .done(done), .err(err), .q_out(q_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] clmul(input logic [W-1:0] p, input logic [W-1:0] r);
        logic [63:0] acc = '0;
        for (int i = 0; i < W; i++)
            if (r[i]) acc ^= (64'(p) << i);
        return acc;
    endfunction

    function automatic logic [63:0] polyred(input logic [63:0] val, input logic [W-1:0] m,
                                            input int len);
        logic [63:0] r = val;
        for (int i = 63; i >= len - 1; i--)
            if (r[i]) r ^= (64'(m) << (i - (len - 1)));
        return r;
    endfunction

    // Product check in the selected field; returns the reduced product.
    function automatic logic [63:0] prod_mod(input vec_t v, input logic [W-1:0] q);
        longint unsigned qq, yy, mm;
        if (v.fld) return polyred(clmul(q, v.y), v.m, int'(v.len));
        qq = 64'(q); yy = 64'(v.y); mm = 64'(v.m);
        return (qq * yy) % mm;
    endfunction

    function automatic bit in_range(input vec_t v, input logic [W-1:0] q);
        if (v.fld) return 64'(q) < (64'd1 << (int'(v.len) - 1));
        return q < v.m;
    endfunction

    task automatic run_op(input vec_t v, output logic [W-1:0] q, output logic e,
                          output int cyc);
        @(negedge clk);
        field_sel = v.fld; len_in = v.len; x_in = v.x; y_in = v.y; m_in = v.m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "R8 op timeout", 64'(cyc), 64'd0);
        q = q_out;
        e = err;
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] q;
        logic         e;
        int           cyc;
        vec_t         v;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && q_out == '0, "R1 reset outputs",
            {busy, done, err, q_out}, 64'd0);
        rst_n = 1'b1;

        // Table walk: R3/R4/R6/R7 results, R8 latency bound
        for (int i = 0; i < NV; i++) begin
            v = VT[i];
            run_op(v, q, e, cyc);
            if (v.xerr) begin
                chk(e == 1'b1 && q == '0, "R7 no quotient -> err", {e, q}, {1'b1, 32'd0});
            end else begin
                chk(e == 1'b0, v.fld ? "R4 err clear" : "R3 err clear", 64'(e), 64'd0);
                chk(in_range(v, q) && prod_mod(v, q) == 64'(v.x),
                    v.fld ? "R4 q*Y mod M == X" : "R3 q*Y mod M == X",
                    prod_mod(v, q), 64'(v.x));
                if (v.x == '0) chk(q == '0, "R6 zero dividend", 64'(q), 64'd0);
            end
            chk(cyc <= 2 * int'(v.len) + 2, "R8 latency bound", 64'(cyc),
                64'(2 * int'(v.len) + 2));
        end

        // R4 known value
        run_op('{1'b1, 6'd9, 32'h1, 32'h53, 32'h11B, 1'b0}, q, e, cyc);
        chk(q == 32'hCA, "R4 known inverse", 64'(q), 64'hCA);

        // R5 divisor one: quotient equals X, done two cycles after start
        run_op('{1'b0, 6'd32, 32'hABCDEF01, 32'd1, 32'hFFFFFFFB, 1'b0}, q, e, cyc);
        chk(q == 32'hABCDEF01, "R5 Y=1 quotient", 64'(q), 64'hABCDEF01);
        chk(cyc == 2, "R5 Y=1 latency", 64'(cyc), 64'd2);

        // R2 done pulse and held result
        @(negedge clk);
        chk(!done && !busy, "R2 done one cycle", {done, busy}, 64'd0);
        repeat (3) @(negedge clk);
        chk(q_out == 32'hABCDEF01 && !err, "R2 result held", 64'(q_out), 64'hABCDEF01);

        // R10 same operands at two lengths
        run_op('{1'b0, 6'd5, 32'd7, 32'd3, 32'd23, 1'b0}, q, e, cyc);
        chk(q == 32'd10, "R10 len=5", 64'(q), 64'd10);
        run_op('{1'b0, 6'd32, 32'd7, 32'd3, 32'd23, 1'b0}, q, e, cyc);
        chk(q == 32'd10, "R10 len=32", 64'(q), 64'd10);

        // R8 round limit forced by a too-short length
        run_op('{1'b0, 6'd2, 32'd1, 32'd987654321, 32'hFFFFFFFB, 1'b0}, q, e, cyc);
        chk(e == 1'b1 && q == '0, "R8 round limit err", {e, q}, {1'b1, 32'd0});
        chk(cyc == 6, "R8 round limit timing", 64'(cyc), 64'd6);

        // R9 start while busy is ignored
        v = '{1'b0, 6'd32, 32'd123456789, 32'd987654321, 32'hFFFFFFFB, 1'b0};
        @(negedge clk);
        field_sel = v.fld; len_in = v.len; x_in = v.x; y_in = v.y; m_in = v.m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy, "R2 busy after start", 64'(busy), 64'd1);
        field_sel = 1'b1; len_in = 6'd5; x_in = 32'd3; y_in = 32'd1; m_in = 32'h13;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!err && in_range(v, q_out) && prod_mod(v, q_out) == 64'(v.x),
            "R9 ignored restart", prod_mod(v, q_out), 64'(v.x));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule